// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits between interrupt source controllers and one processor. It keeps a 32-bit pending word: the processor's current priority in the top byte and the number of the pending source in the low 24 bits, where a source number of zero means nothing is pending. It also holds a pending-priority byte and an inter-processor-interrupt (IPI) priority byte. Priorities are inverted: smaller values are more favoured, and 0xFF is the least favoured value, at which nothing can be delivered.

Sources present an offer with a source number and a priority. The presenter takes the offer if it beats both the processor priority and whatever is already pending; otherwise it answers with a negative acknowledge. An external source that is pushed out by a better offer, by an IPI or by a priority raise is handed back to its owner on a separate bounce channel. The processor drives single-cycle operations: accept-read, poll-read, priority write, IPI-priority write and end-of-interrupt write. An end-of-interrupt is forwarded to the sources. When a change could let an earlier refused source through, the presenter asks the sources to resend.

All results are registered and appear one clock after the stimulus.

Top module: `irq_presenter`

## Requirements
- R1: After reset the pending word reads 0x00000000, the IPI priority reads 0xFF, the interrupt output is low and every strobe is low.
- R2: An offer with priority p and a non-zero source number, arriving with no operation, is taken when p is below the current priority and either nothing is pending or p is below the pending priority. The output is then high, the source field holds the new number, and the pending priority is p.
- R3: When a taken offer replaces a pending source that came from a source controller, the bounce strobe pulses with that source's number.
- R4: An offer is refused when p is at or above the current priority, or when a source is pending with a pending priority at or below p. A refused offer pulses offer_nack and leaves the pending word unchanged. With a current priority of 0, every offer is refused.
- R5: Op codes are 1 accept, 2 poll, 3 priority write (wdata[7:0]), 4 IPI-priority write (wdata[7:0]) and 5 end-of-interrupt (wdata[31:24] priority, wdata[23:0] source). Other codes have no effect. Read results appear on rd_data/rd_ipi with rd_valid.
- R6: An IPI-priority write below the current priority runs the IPI check. If nothing is pending, or the pending priority is above the IPI priority, the check bounces any external source. It then sets the source field to 2 and the pending priority to the IPI priority, and raises the output. Otherwise nothing changes except the stored IPI priority.
- R7: An IPI-priority write at or above the current priority only stores the value.
- R8: An accept-read returns the whole pending word and lowers the output. It loads the current priority with the pending priority, clears the source field and sets the pending priority to 0xFF.
- R9: A priority write with a more favoured value clears a pending source whose pending priority is at or above the new value. It also sets the pending priority to 0xFF, lowers the output and bounces an external source. A pending source with a pending priority below the new value stays.
- R10: A priority write with an equal or less favoured value while nothing is pending pulses resend_req. Before that, it runs the IPI check if the IPI priority is below the new current priority.
- R11: An end-of-interrupt write loads the current priority and pulses eoi_valid with the written source. If nothing is pending, it also performs the resend of R10.
- R12: A poll-read returns the pending word and the IPI priority with no other effect.
- R13: An offer in the same cycle as any operation is refused with offer_nack. An IPI source that is replaced is never bounced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | Source offer strobe |
| offer_src | input | 24 | Offered source number (non-zero) |
| offer_prio | input | 8 | Offered priority |
| offer_nack | output | 1 | Offer of the previous cycle was refused |
| bounce_valid | output | 1 | A displaced external source is returned |
| bounce_src | output | 24 | Number of the returned source |
| op_valid | input | 1 | Processor operation strobe |
| op_code | input | 3 | Operation code |
| op_wdata | input | 32 | Write value for priority, IPI and EOI writes |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Pending word returned by accept or poll |
| rd_ipi | output | 8 | IPI priority returned by poll |
| eoi_valid | output | 1 | End-of-interrupt strobe to sources |
| eoi_src | output | 24 | Source being completed |
| resend_req | output | 1 | Request that sources resend refused interrupts |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
Every result is one register stage from its cause. Strobes, read data and the interrupt line all change at the clock edge that samples the offer or operation, and the strobes drop again one edge later. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It checks the outputs right then, half a period after the edge that produced them. State changes are confirmed with a following poll, whose result lands one edge after that poll.

// File: rtl/irq_presenter.sv
module irq_presenter #(
  parameter int SRC_W   = 24,
  parameter int PRI_W   = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    offer_valid,
  input  logic [SRC_W-1:0]        offer_src,
  input  logic [PRI_W-1:0]        offer_prio,
  output logic                    offer_nack,
  output logic                    bounce_valid,
  output logic [SRC_W-1:0]        bounce_src,
  input  logic                    op_valid,
  input  logic [2:0]              op_code,
  input  logic [PRI_W+SRC_W-1:0]  op_wdata,
  output logic                    rd_valid,
  output logic [PRI_W+SRC_W-1:0]  rd_data,
  output logic [PRI_W-1:0]        rd_ipi,
  output logic                    eoi_valid,
  output logic [SRC_W-1:0]        eoi_src,
  output logic                    resend_req,
  output logic                    irq_out
);
  localparam int WORD_W = PRI_W + SRC_W;
  localparam logic [PRI_W-1:0] LEAST = '1;
  localparam logic [SRC_W-1:0] NONE  = '0;
  localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

  localparam logic [2:0] OP_ACCEPT = 3'd1;
  localparam logic [2:0] OP_POLL   = 3'd2;
  localparam logic [2:0] OP_PRIO   = 3'd3;
  localparam logic [2:0] OP_IPI    = 3'd4;
  localparam logic [2:0] OP_EOI    = 3'd5;

  logic [PRI_W-1:0] cur_q, pend_q, ipi_q;
  logic [SRC_W-1:0] src_q;
  logic             ext_q;

  logic [PRI_W-1:0] cur_d, pend_d, ipi_d;
  logic [SRC_W-1:0] src_d;
  logic             ext_d, irq_d;
  logic             nack_d, bnc_d, rdv_d, eoi_d, rsd_d;
  logic [SRC_W-1:0] bnc_src_d, eoi_src_d;
  logic [WORD_W-1:0] rd_d;
  logic             ipi_chk;

  wire [PRI_W-1:0] wr_pri = op_wdata[PRI_W-1:0];

  always_comb begin
    cur_d = cur_q; pend_d = pend_q; ipi_d = ipi_q; src_d = src_q;
    ext_d = ext_q; irq_d = irq_out;
    nack_d = 1'b0; bnc_d = 1'b0; bnc_src_d = bounce_src;
    rdv_d = 1'b0; rd_d = rd_data;
    eoi_d = 1'b0; eoi_src_d = eoi_src; rsd_d = 1'b0;
    ipi_chk = 1'b0;

    if (op_valid) begin
      nack_d = offer_valid;
      case (op_code)
        OP_ACCEPT: begin
          rdv_d = 1'b1;
          rd_d  = {cur_q, src_q};
          cur_d = pend_q; src_d = NONE; pend_d = LEAST;
          ext_d = 1'b0; irq_d = 1'b0;
        end
        OP_POLL: begin
          rdv_d = 1'b1;
          rd_d  = {cur_q, src_q};
        end
        OP_PRIO: begin
          cur_d = wr_pri;
          if (wr_pri < cur_q) begin
            if (src_q != NONE && wr_pri <= pend_q) begin
              src_d = NONE; pend_d = LEAST; irq_d = 1'b0; ext_d = 1'b0;
              if (ext_q) begin
                bnc_d = 1'b1; bnc_src_d = src_q;
              end
            end
          end else if (src_q == NONE) begin
            rsd_d   = 1'b1;
            ipi_chk = ipi_q < wr_pri;
          end
        end
        OP_IPI: begin
          ipi_d   = wr_pri;
          ipi_chk = wr_pri < cur_q;
        end
        OP_EOI: begin
          cur_d     = op_wdata[WORD_W-1:SRC_W];
          eoi_d     = 1'b1;
          eoi_src_d = op_wdata[SRC_W-1:0];
          if (src_q == NONE) begin
            rsd_d   = 1'b1;
            ipi_chk = ipi_q < op_wdata[WORD_W-1:SRC_W];
          end
        end
        default: ;
      endcase

      if (ipi_chk && !(src_d != NONE && pend_d <= ipi_d)) begin
        if (src_d != NONE && ext_d) begin
          bnc_d = 1'b1; bnc_src_d = src_d;
        end
        src_d = IPI_NUM; pend_d = ipi_d; ext_d = 1'b0; irq_d = 1'b1;
      end
    end else if (offer_valid) begin
      if (offer_prio >= cur_q || (src_q != NONE && pend_q <= offer_prio)) begin
        nack_d = 1'b1;
      end else begin
        if (src_q != NONE && ext_q) begin
          bnc_d = 1'b1; bnc_src_d = src_q;
        end
        src_d = offer_src; pend_d = offer_prio; ext_d = 1'b1; irq_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0; src_q <= NONE; pend_q <= LEAST; ipi_q <= LEAST; ext_q <= 1'b0;
      irq_out <= 1'b0; offer_nack <= 1'b0; bounce_valid <= 1'b0; bounce_src <= NONE;
      rd_valid <= 1'b0; rd_data <= '0; rd_ipi <= LEAST;
      eoi_valid <= 1'b0; eoi_src <= NONE; resend_req <= 1'b0;
    end else begin
      cur_q <= cur_d; src_q <= src_d; pend_q <= pend_d; ipi_q <= ipi_d; ext_q <= ext_d;
      irq_out <= irq_d; offer_nack <= nack_d;
      bounce_valid <= bnc_d; bounce_src <= bnc_src_d;
      rd_valid <= rdv_d; rd_data <= rd_d;
      if (op_valid && op_code == OP_POLL) rd_ipi <= ipi_q;
      eoi_valid <= eoi_d; eoi_src <= eoi_src_d; resend_req <= rsd_d;
    end
  end

  AST_IRQ_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> src_q != NONE); // R2
  AST_LOW_OFFER_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid && !op_valid && offer_prio >= cur_q |=> offer_nack && $stable(src_q)); // R4
  AST_TAKEN_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid && !op_valid && offer_src != NONE && offer_prio < cur_q &&
    (src_q == NONE || offer_prio < pend_q) |=> irq_out && src_q == $past(offer_src)); // R2
  AST_ACCEPT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_ACCEPT |=> !irq_out && rd_valid && src_q == NONE); // R8
  AST_POLL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_POLL |=> $stable(irq_out) && $stable(src_q) && !bounce_valid); // R12
  AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && offer_valid |=> offer_nack); // R13
endmodule

// File: tb/irq_presenter_tb.sv
module irq_presenter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic offer_valid = 1'b0;
  logic [23:0] offer_src = '0;
  logic [7:0] offer_prio = '0;
  logic op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic [31:0] op_wdata = '0;
  logic offer_nack, bounce_valid, rd_valid, eoi_valid, resend_req, irq_out;
  logic [23:0] bounce_src, eoi_src;
  logic [31:0] rd_data;
  logic [7:0] rd_ipi;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_presenter u_dut (
    .clk(clk), .rst_n(rst_n),
    .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
    .offer_nack(offer_nack), .bounce_valid(bounce_valid), .bounce_src(bounce_src),
    .op_valid(op_valid), .op_code(op_code), .op_wdata(op_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ipi(rd_ipi),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit ov, input logic [2:0] oc, input logic [31:0] wd,
                      input bit fv, input logic [23:0] fs, input logic [7:0] fp);
    @(negedge clk);
    op_valid = ov; op_code = oc; op_wdata = wd;
    offer_valid = fv; offer_src = fs; offer_prio = fp;
    @(negedge clk);
    op_valid = 1'b0; offer_valid = 1'b0;
  endtask

  task automatic op(input logic [2:0] oc, input logic [31:0] wd);
    step(1'b1, oc, wd, 1'b0, '0, '0);
  endtask

  task automatic offer(input logic [23:0] s, input logic [7:0] p);
    step(1'b0, 3'd0, '0, 1'b1, s, p);
  endtask

  task automatic poll_is(input string req, input logic [31:0] word, input logic [7:0] ipi);
    op(3'd2, '0);
    chk(req, rd_data, word);
    chk(req, {24'd0, rd_ipi}, {24'd0, ipi});
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'd0, irq_out}, 0);
    chk("R1 strobes", {27'd0, offer_nack, bounce_valid, eoi_valid, resend_req, rd_valid}, 0);
    poll_is("R1 poll", 32'h0000_0000, 8'hFF);
  endtask

  task automatic t_offers;
    offer(24'h10, 8'h05);
    chk("R4 zero cppr nack", {31'd0, offer_nack}, 1);
    chk("R4 irq stays low", {31'd0, irq_out}, 0);
    op(3'd3, 32'hFF);
    chk("R10 resend", {31'd0, resend_req}, 1);
    chk("R10 no ipi", {31'd0, irq_out}, 0);
    offer(24'h10, 8'h05);
    chk("R2 taken", {30'd0, offer_nack, irq_out}, 1);
    poll_is("R2 poll", 32'hFF00_0010, 8'hFF);
    offer(24'h20, 8'h05);
    chk("R4 equal pending nack", {31'd0, offer_nack}, 1);
    offer(24'h30, 8'h03);
    chk("R3 bounce valid", {31'd0, bounce_valid}, 1);
    chk("R3 bounce src", {8'd0, bounce_src}, 32'h30 - 32'h20);
    poll_is("R3 poll", 32'hFF00_0030, 8'hFF);
  endtask

  task automatic t_busy_accept_eoi;
    step(1'b1, 3'd2, '0, 1'b1, 24'h40, 8'h01);
    chk("R13 busy nack", {31'd0, offer_nack}, 1);
    chk("R13 poll word", rd_data, 32'hFF00_0030);
    op(3'd1, '0);
    chk("R8 accept word", rd_data, 32'hFF00_0030);
    chk("R8 accept valid", {31'd0, rd_valid}, 1);
    chk("R8 irq low", {31'd0, irq_out}, 0);
    poll_is("R8 after accept", 32'h0300_0000, 8'hFF);
    op(3'd5, 32'hFF00_0030);
    chk("R11 eoi strobe", {31'd0, eoi_valid}, 1);
    chk("R11 eoi src", {8'd0, eoi_src}, 32'h30);
    chk("R11 resend", {31'd0, resend_req}, 1);
    poll_is("R11 cppr", 32'hFF00_0000, 8'hFF);
  endtask

  task automatic t_ipi;
    op(3'd4, 32'h04);
    chk("R6 ipi irq", {31'd0, irq_out}, 1);
    chk("R6 no bounce", {31'd0, bounce_valid}, 0);
    poll_is("R6 ipi word", 32'hFF00_0002, 8'h04);
    offer(24'h50, 8'h02);
    chk("R13 ipi not bounced", {31'd0, bounce_valid}, 0);
    poll_is("R13 word", 32'hFF00_0050, 8'h04);
    op(3'd4, 32'h06);
    chk("R6 kept pending", {31'd0, bounce_valid}, 0);
    poll_is("R6 unchanged", 32'hFF00_0050, 8'h06);
    op(3'd4, 32'h01);
    chk("R6 bounce ext", {31'd0, bounce_valid}, 1);
    chk("R6 bounce src", {8'd0, bounce_src}, 32'h50);
    poll_is("R6 ipi wins", 32'hFF00_0002, 8'h01);
    op(3'd1, '0);
    chk("R8 accept ipi", rd_data, 32'hFF00_0002);
    op(3'd4, 32'h03);
    chk("R7 no irq", {31'd0, irq_out}, 0);
    poll_is("R7 stored only", 32'h0100_0000, 8'h03);
  endtask

  task automatic t_priority;
    op(3'd3, 32'hFF);
    chk("R10 resend", {31'd0, resend_req}, 1);
    chk("R10 ipi check irq", {31'd0, irq_out}, 1);
    poll_is("R10 ipi pending", 32'hFF00_0002, 8'h03);
    op(3'd4, 32'hFF);
    offer(24'h60, 8'h01);
    chk("R13 no bounce of ipi", {31'd0, bounce_valid}, 0);
    op(3'd3, 32'h01);
    chk("R9 irq low", {31'd0, irq_out}, 0);
    chk("R9 bounce", {7'd0, bounce_valid, bounce_src}, 32'h0100_0060);
    poll_is("R9 cleared", 32'h0100_0000, 8'hFF);
    op(3'd3, 32'hFF);
    offer(24'h70, 8'h08);
    op(3'd3, 32'h09);
    chk("R9 keep better", {30'd0, bounce_valid, irq_out}, 1);
    poll_is("R9 kept", 32'h0900_0070, 8'hFF);
    op(3'd5, 32'hFF00_0070);
    chk("R11 no resend when pending", {31'd0, resend_req}, 0);
    chk("R11 eoi src", {8'd0, eoi_src}, 32'h70);
    poll_is("R11 cppr loaded", 32'hFF00_0070, 8'hFF);
    op(3'd7, 32'h0000_0001);
    chk("R5 bad code quiet", {28'd0, rd_valid, eoi_valid, resend_req, irq_out}, 1);
    poll_is("R12 poll stable", 32'hFF00_0070, 8'hFF);
    chk("R12 irq kept", {31'd0, irq_out}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_offers();
    t_busy_accept_eoi();
    t_ipi();
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule